// File: doc/BRIEF.md
# PWM Output Override Selector

This block sits between a bank of PWM channel generators and the output pins. Every channel drives a complementary pair of outputs, a high side and a low side. For each of those outputs the block holds one selection bit. When the bit is clear, the generated waveform goes to the pin unchanged. When it is set, the pin takes a forced level from a per-channel value register. The generators are never stalled or reset by this block. Only the pin value is replaced, so the waveform is back on the pin as soon as an override is released.

Software changes the selection through a small register port that has one write port and one read port. The direct set and clear registers act on the selection at the next clock edge. The buffered set and clear registers only record a pending request. Each channel applies its own pending requests when its period-start pulse arrives, so a change lands on a waveform boundary. The live selection and the value register can be read back at any time.

Top module: `pwm_ovr_sel`

## Requirements
- R1: After reset, the selection word and the value word both read 0, and every pin follows its waveform input.
- R2: Writing address 0 sets the selection bits that are 1 in the data. Writing address 1 clears the selection bits that are 1 in the data. The new selection is visible on the rising edge that captures the write, whatever period_start does. It is not visible before that edge.
- R3: Writing address 2 (set) or address 3 (clear) records a pending request and does not change the selection. The request is applied on the rising edge at which period_start[c] of the owning channel is high. A period-start pulse of any other channel leaves it pending.
- R4: If a bit has both a pending buffered set and a pending buffered clear when its period start arrives, the bit is cleared. Both requests are then discarded.
- R5: A direct write takes effect at once, even while a buffered request for the same bit is pending. That pending request is still applied at the next period start. If a direct write and a period start hit the same bit in the same cycle, the direct write decides the bit and the pending request is discarded.
- R6: A buffered write made in the same cycle as that channel's period start is not applied by that pulse. It is applied at the following period start.
- R7: A pin whose selection bit is 0 equals its waveform input, with no added latency. A pin whose selection bit is 1 equals its bit of the value word.
- R8: Bit layout of every data word: bit c is the high output of channel c and bit 16+c is the low output of channel c. Address 4 is the value word and can be read and written. Address 5 reads the live selection. Reads of addresses 0 to 3 return 0.
- R9: Writes to address 5, 6 or 7 change nothing. Addresses 6 and 7 read 0. Bits for channels at or above NUM_CH are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| period_start | input | NUM_CH | Per-channel period-start pulse |
| wave_h | input | NUM_CH | Generated high-side waveforms |
| wave_l | input | NUM_CH | Generated low-side waveforms |
| pin_h | output | NUM_CH | High-side pin values |
| pin_l | output | NUM_CH | Low-side pin values |

## Verification
The hardest situations to reach are the collisions between the two update paths. One is a direct write that lands in the same cycle as the period-start pulse of a channel with a request still pending. The other is a buffered write that arrives together with its own channel's pulse. The bench drives both in one cycle, write strobe and period_start together on the same falling edge. It then sends a second pulse, which shows whether the stale request was discarded (R5) or only deferred (R6). A pending set and a pending clear on the same bit are also built up over two writes before a single pulse. That pulse shows that the clear wins (R4).

// File: rtl/pwm_ovr_pkg.sv
package pwm_ovr_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int LO_BASE = DATA_W / 2;

    typedef enum logic [ADDR_W-1:0] {
        A_DSET = 3'd0,
        A_DCLR = 3'd1,
        A_BSET = 3'd2,
        A_BCLR = 3'd3,
        A_VAL  = 3'd4,
        A_SEL  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic dset;
        logic dclr;
        logic bset;
        logic bclr;
        logic vwr;
    } wr_strobe_t;

    typedef enum logic {SIDE_HI = 1'b0, SIDE_LO = 1'b1} side_e;

    function automatic int bit_pos(input int ch, input side_e side);
        return (side == SIDE_LO) ? (LO_BASE + ch) : ch;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input int num_ch);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < LO_BASE; c++) begin
            if (c < num_ch) begin
                m[c]           = 1'b1;
                m[LO_BASE + c] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_ovr_regif.sv
module pwm_ovr_regif
    import pwm_ovr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] sel_word,
    input  logic [DATA_W-1:0] val_word,
    output wr_strobe_t        stb,
    output logic [DATA_W-1:0] wr_bits,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W-1:0] VMASK = lane_mask(NUM_CH);

    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (wr_addr)
                A_DSET:  stb.dset = 1'b1;
                A_DCLR:  stb.dclr = 1'b1;
                A_BSET:  stb.bset = 1'b1;
                A_BCLR:  stb.bclr = 1'b1;
                A_VAL:   stb.vwr  = 1'b1;
                default: stb      = '0;
            endcase
        end
    end

    assign wr_bits = wr_data & VMASK;

    always_comb begin
        case (rd_addr)
            A_VAL:   rd_data = val_word & VMASK;
            A_SEL:   rd_data = sel_word & VMASK;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm_ovr_bit.sv
module pwm_ovr_bit
    import pwm_ovr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_strobe_t stb,
    input  logic       wbit,
    input  logic       pstart,
    output logic       sel,
    output logic       val
);

    logic sel_q, sel_d;
    logic pend_s_q, pend_s_d;
    logic pend_c_q, pend_c_d;
    logic val_q, val_d;

    always_comb begin
        sel_d = sel_q;
        if (pstart) begin
            if (pend_c_q)      sel_d = 1'b0;
            else if (pend_s_q) sel_d = 1'b1;
        end
        if (stb.dset && wbit) sel_d = 1'b1;
        if (stb.dclr && wbit) sel_d = 1'b0;

        pend_s_d = pstart ? 1'b0 : pend_s_q;
        pend_c_d = pstart ? 1'b0 : pend_c_q;
        if (stb.bset && wbit) pend_s_d = 1'b1;
        if (stb.bclr && wbit) pend_c_d = 1'b1;

        val_d = stb.vwr ? wbit : val_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            pend_s_q <= 1'b0;
            pend_c_q <= 1'b0;
            val_q    <= 1'b0;
        end else begin
            sel_q    <= sel_d;
            pend_s_q <= pend_s_d;
            pend_c_q <= pend_c_d;
            val_q    <= val_d;
        end
    end

    assign sel = sel_q;
    assign val = val_q;

endmodule

// File: rtl/pwm_ovr_pinmux.sv
module pwm_ovr_pinmux (
    input  logic wave_h,
    input  logic wave_l,
    input  logic sel_h,
    input  logic sel_l,
    input  logic val_h,
    input  logic val_l,
    output logic pin_h,
    output logic pin_l
);

    always_comb begin
        pin_h = sel_h ? val_h : wave_h;
        pin_l = sel_l ? val_l : wave_l;
    end

endmodule

// File: rtl/pwm_ovr_sel.sv
module pwm_ovr_sel
    import pwm_ovr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NUM_CH-1:0] period_start,
    input  logic [NUM_CH-1:0] wave_h,
    input  logic [NUM_CH-1:0] wave_l,
    output logic [NUM_CH-1:0] pin_h,
    output logic [NUM_CH-1:0] pin_l
);

    localparam int NSIDE = 2;

    wr_strobe_t        stb;
    logic [DATA_W-1:0] wr_bits;
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] val_word;

    pwm_ovr_regif #(.NUM_CH(NUM_CH)) u_regif (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .sel_word (sel_word),
        .val_word (val_word),
        .stb      (stb),
        .wr_bits  (wr_bits),
        .rd_data  (rd_data)
    );

    for (genvar u = 0; u < DATA_W; u++) begin : g_unused
        if ((u % LO_BASE) >= NUM_CH) begin : g_tie
            assign sel_word[u] = 1'b0;
            assign val_word[u] = 1'b0;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            localparam int P = bit_pos(c, side_e'(s));
            pwm_ovr_bit u_bit (
                .clk    (clk),
                .rst    (rst),
                .stb    (stb),
                .wbit   (wr_bits[P]),
                .pstart (period_start[c]),
                .sel    (sel_word[P]),
                .val    (val_word[P])
            );
        end

        pwm_ovr_pinmux u_mux (
            .wave_h (wave_h[c]),
            .wave_l (wave_l[c]),
            .sel_h  (sel_word[c]),
            .sel_l  (sel_word[LO_BASE + c]),
            .val_h  (val_word[c]),
            .val_l  (val_word[LO_BASE + c]),
            .pin_h  (pin_h[c]),
            .pin_l  (pin_l[c])
        );
    end

endmodule

// File: rtl/pwm_ovr_sel_chk.sv
module pwm_ovr_sel_chk
    import pwm_ovr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic [NUM_CH-1:0] period_start,
    input logic [NUM_CH-1:0] wave_h,
    input logic [NUM_CH-1:0] wave_l,
    input logic [NUM_CH-1:0] pin_h,
    input logic [NUM_CH-1:0] pin_l,
    input logic [31:0]       sel_word,
    input logic [31:0]       val_word
);

    localparam logic [DATA_W-1:0] VMASK = lane_mask(NUM_CH);

    logic [NUM_CH-1:0] sel_h, sel_l, val_h, val_l;
    logic              dir_wr, dset_wr, dclr_wr, val_wr;

    assign sel_h   = sel_word[NUM_CH-1:0];
    assign sel_l   = sel_word[LO_BASE +: NUM_CH];
    assign val_h   = val_word[NUM_CH-1:0];
    assign val_l   = val_word[LO_BASE +: NUM_CH];
    assign dset_wr = wr_en && (wr_addr == 3'd0);
    assign dclr_wr = wr_en && (wr_addr == 3'd1);
    assign dir_wr  = dset_wr || dclr_wr;
    assign val_wr  = wr_en && (wr_addr == 3'd4);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (sel_word == '0 && val_word == '0));

    // R2
    a_r2_direct_set: assert property (@(posedge clk) disable iff (rst)
        dset_wr |=> ((sel_word & $past(wr_data & VMASK)) == $past(wr_data & VMASK)));

    a_r2_direct_clr: assert property (@(posedge clk) disable iff (rst)
        dclr_wr |=> ((sel_word & $past(wr_data & VMASK)) == '0));

    // R3
    a_r3_hold_without_boundary: assert property (@(posedge clk) disable iff (rst)
        (!dir_wr && period_start == '0) |=> $stable(sel_word));

    // R7
    a_r7_pass_high: assert property (@(posedge clk) disable iff (rst)
        ((pin_h ^ wave_h) & ~sel_h) == '0);

    a_r7_pass_low: assert property (@(posedge clk) disable iff (rst)
        ((pin_l ^ wave_l) & ~sel_l) == '0);

    a_r7_forced: assert property (@(posedge clk) disable iff (rst)
        (((pin_h ^ val_h) & sel_h) == '0) && (((pin_l ^ val_l) & sel_l) == '0));

    // R8
    a_r8_val_hold: assert property (@(posedge clk) disable iff (rst)
        !val_wr |=> $stable(val_word));

    // R9
    a_r9_unused_lanes: assert property (@(posedge clk) disable iff (rst)
        ((sel_word | val_word) & ~VMASK) == '0);

endmodule

bind pwm_ovr_sel pwm_ovr_sel_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .period_start (period_start),
    .wave_h       (wave_h),
    .wave_l       (wave_l),
    .pin_h        (pin_h),
    .pin_l        (pin_l),
    .sel_word     (sel_word),
    .val_word     (val_word)
);

// File: tb/pwm_ovr_sel_tb.sv
module pwm_ovr_sel_tb;

    localparam int NUM_CH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [2:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NUM_CH-1:0] period_start = '0;
    logic [NUM_CH-1:0] wave_h = '0;
    logic [NUM_CH-1:0] wave_l = '0;
    logic [NUM_CH-1:0] pin_h, pin_l;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwm_ovr_sel #(.NUM_CH(NUM_CH)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .period_start (period_start),
        .wave_h       (wave_h),
        .wave_l       (wave_l),
        .pin_h        (pin_h),
        .pin_l        (pin_l)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] m);
        @(negedge clk);
        period_start = m;
        @(negedge clk);
        period_start = '0;
    endtask

    task automatic wr_with_pulse(input logic [2:0] a, input logic [31:0] d, input logic [NUM_CH-1:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; period_start = m;
        @(negedge clk);
        wr_en = 1'b0; period_start = '0;
    endtask

    task automatic t_reset;
        read_chk("R1 sel", 3'd5, 32'h0);
        read_chk("R1 val", 3'd4, 32'h0);
        wave_h = 4'b1010; wave_l = 4'b0101;
        #1;
        check("R1 pins", {8'h0, pin_h, pin_l}, {8'h0, 4'b1010, 4'b0101});
    endtask

    task automatic t_direct;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0001_0002; period_start = '0;
        rd_addr = 3'd5;
        #1;
        check("R2 not before edge", rd_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        read_chk("R2 direct set", 3'd5, 32'h0001_0002);
        wr(3'd1, 32'h0000_0002);
        read_chk("R2 direct clear", 3'd5, 32'h0001_0000);
        read_chk("R8 set reg reads 0", 3'd0, 32'h0);
    endtask

    task automatic t_values;
        wr(3'd4, 32'h0001_0003);
        read_chk("R8 val readback", 3'd4, 32'h0001_0003);
        wave_h = 4'b0000; wave_l = 4'b0000;
        #1;
        check("R7 forced low side", {28'h0, pin_l}, 32'h1);
        check("R7 high passes", {28'h0, pin_h}, 32'h0);
        wave_h = 4'b1111; wave_l = 4'b1111;
        wr(3'd4, 32'h0);
        #1;
        check("R7 forced zero", {28'h0, pin_l}, 32'he);
        wr(3'd1, 32'h0001_0000);
        #1;
        check("R7 release follows wave", {24'h0, pin_h, pin_l}, 32'hff);
        wave_l = 4'b0110;
        #1;
        check("R7 wave runs on", {28'h0, pin_l}, 32'h6);
    endtask

    task automatic t_buffered;
        wr(3'd2, 32'h0000_0008);
        read_chk("R3 buffered waits", 3'd5, 32'h0);
        pulse(4'b0001);
        read_chk("R3 other channel pulse", 3'd5, 32'h0);
        pulse(4'b1000);
        read_chk("R3 applied at own pulse", 3'd5, 32'h0000_0008);
    endtask

    task automatic t_clear_wins;
        wr(3'd2, 32'h0008_0008);
        wr(3'd3, 32'h0000_0008);
        read_chk("R4 still waiting", 3'd5, 32'h0000_0008);
        pulse(4'b1000);
        read_chk("R4 clear wins", 3'd5, 32'h0008_0000);
    endtask

    task automatic t_direct_vs_pending;
        wr(3'd3, 32'h0000_0004);
        wr(3'd0, 32'h0000_0004);
        read_chk("R5 direct immediate", 3'd5, 32'h0008_0004);
        pulse(4'b0100);
        read_chk("R5 pending still applied", 3'd5, 32'h0008_0000);
        wr(3'd2, 32'h0000_0004);
        wr_with_pulse(3'd1, 32'h0000_0004, 4'b0100);
        read_chk("R5 same cycle direct wins", 3'd5, 32'h0008_0000);
        pulse(4'b0100);
        read_chk("R5 pending discarded", 3'd5, 32'h0008_0000);
    endtask

    task automatic t_write_at_pulse;
        wr_with_pulse(3'd2, 32'h0000_0001, 4'b0001);
        read_chk("R6 not taken by same pulse", 3'd5, 32'h0008_0000);
        pulse(4'b0001);
        read_chk("R6 taken by next pulse", 3'd5, 32'h0008_0001);
    endtask

    task automatic t_ignored;
        wr(3'd5, 32'hffff_ffff);
        wr(3'd6, 32'hffff_ffff);
        wr(3'd7, 32'hffff_ffff);
        read_chk("R9 sel untouched", 3'd5, 32'h0008_0001);
        read_chk("R9 val untouched", 3'd4, 32'h0);
        read_chk("R9 addr6 reads 0", 3'd6, 32'h0);
        read_chk("R9 addr7 reads 0", 3'd7, 32'h0);
        wr(3'd0, 32'hffff_ffff);
        read_chk("R9 unused lanes sel", 3'd5, 32'h000f_000f);
        wr(3'd4, 32'hffff_ffff);
        read_chk("R9 unused lanes val", 3'd4, 32'h000f_000f);
        wave_h = '0; wave_l = '0;
        #1;
        check("R7 all forced high", {24'h0, pin_h, pin_l}, 32'hff);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_values();
        t_buffered();
        t_clear_wins();
        t_direct_vs_pending();
        t_write_at_pulse();
        t_ignored();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule